// File: doc/BRIEF.md
# Overwriting Receive Log FIFO Bank with Status and Interrupt

This block stores received serial messages that have already passed a label filter. It keeps one log queue per receive channel. There are eight channels, and each queue holds up to 32 words of 32 bits. A filter delivers an accepted word together with its channel index. The host removes words one at a time by giving a read strobe and a channel index. The word comes back on a registered read port in the following cycle.

When a queue is full, the newest word is still stored and the oldest word is discarded. The log therefore always holds the most recent traffic. Each channel reports three conditions: holding data, holding more words than a programmable threshold, and full. These conditions are gathered into three 8-bit status vectors, where bit n belongs to channel n.

A 2-bit selector for each channel picks which of the three conditions raises that channel's flag. All channel flags are ORed into one interrupt-pending output.

Top module: `rxlog_fifo_bank`

## Requirements
- R1: After reset every queue is empty, the three status vectors and the channel flags are zero, `irq_pending` is 0 and `rd_data` is 0.
- R2: A push to channel n sets `stat_nempty[n]` in the cycle after the push.
- R3: `stat_thresh[n]` is 1 exactly when the occupancy of queue n (0 to 32) is strictly greater than the 5-bit `thresh` value. It updates one cycle after a push, a pop or a threshold change.
- R4: `stat_full[n]` is 1 exactly when queue n holds 32 words, and occupancy never exceeds 32.
- R5: A push to a full queue is accepted. The oldest word is discarded, and occupancy stays at 32.
- R6: Words are read out of each queue in the order they were written. `rd_data` shows the word one cycle after `rd_strobe`.
- R7: A read strobe on an empty queue returns zero on `rd_data` and leaves the occupancy unchanged.
- R8: A push and a pop to the same full queue in the same cycle return the oldest word, and the queue stays full.
- R9: Queues are independent. Traffic on one channel never changes the status bits of another channel.
- R10: Channel n's selector is `flag_sel[2n+1:2n]`. Code 00 gives no flag, 01 selects not-empty, 10 selects threshold and 11 selects full. The result is shown on `chan_flag[n]` without a clock delay.
- R11: `irq_pending` is the combinational OR of all `chan_flag` bits.
- R12: `rd_data` holds its value in every cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Accepted message is present this cycle |
| wr_chan | input | 3 | Channel of the accepted message |
| wr_data | input | 32 | Accepted message word |
| rd_strobe | input | 1 | Host pops one word |
| rd_chan | input | 3 | Channel to pop from |
| thresh | input | 5 | Threshold for the threshold status bits |
| flag_sel | input | 16 | Per-channel 2-bit flag source selectors |
| rd_data | output | 32 | Popped word, registered |
| stat_nempty | output | 8 | Per-channel not-empty bits |
| stat_thresh | output | 8 | Per-channel above-threshold bits |
| stat_full | output | 8 | Per-channel full bits |
| chan_flag | output | 8 | Per-channel selected flag |
| irq_pending | output | 1 | OR of all channel flags |

## Verification
The hardest case to reach is a full queue that is being overwritten. It is made harder when a push and a pop arrive together on that full queue. Both pointers must then advance while the data being read is the slot that is also being written. The stimulus fills one channel with 40 distinct words, so eight of them are overwritten. It then issues a combined push and pop on that channel and drains it. The scoreboard queue predicts every popped word, so any loss of order, or a wrong choice of which word was dropped, shows up as a mismatch.

// File: rtl/rxlog_pkg.sv
package rxlog_pkg;

  typedef enum logic [1:0] {
    FSEL_OFF    = 2'b00,
    FSEL_NEMPTY = 2'b01,
    FSEL_THRESH = 2'b10,
    FSEL_FULL   = 2'b11
  } flag_src_e;

  // Next ring index, wrapping at depth.
  function automatic int unsigned ptr_step(int unsigned p, int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Occupancy after one cycle with the given push/pop requests.
  function automatic int unsigned occ_after(int unsigned occ, logic push, logic pop,
                                            int unsigned depth);
    logic can_pop;
    can_pop = pop && (occ != 0);
    if (push && can_pop) return occ;
    if (push)            return (occ >= depth) ? depth : occ + 1;
    if (can_pop)         return occ - 1;
    return occ;
  endfunction

endpackage

// File: rtl/rxlog_chan_fifo.sv
module rxlog_chan_fifo
  import rxlog_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned THR_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  input  logic [THR_W-1:0]  thr_i,
  output logic [DATA_W-1:0] pop_data_o,
  output logic              nempty_o,
  output logic              thresh_o,
  output logic              full_o
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt, cnt_nxt;

  // Named internal events
  logic at_cap, pop_take, overwrite_ev, rd_adv;
  assign at_cap       = (cnt == CNT_W'(DEPTH));
  assign pop_take     = pop_i && (cnt != '0);
  assign overwrite_ev = push_i && at_cap && !pop_take;
  assign rd_adv       = pop_take || overwrite_ev;
  assign cnt_nxt      = CNT_W'(occ_after(32'(cnt), push_i, pop_i, DEPTH));

  always_ff @(posedge clk) begin
    if (push_i) mem[wr_ptr] <= push_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      cnt      <= '0;
      nempty_o <= 1'b0;
      thresh_o <= 1'b0;
      full_o   <= 1'b0;
    end else begin
      if (push_i) wr_ptr <= PTR_W'(ptr_step(32'(wr_ptr), DEPTH));
      if (rd_adv) rd_ptr <= PTR_W'(ptr_step(32'(rd_ptr), DEPTH));
      cnt      <= cnt_nxt;
      nempty_o <= (cnt_nxt != '0);
      thresh_o <= (32'(cnt_nxt) > 32'(thr_i));
      full_o   <= (cnt_nxt == CNT_W'(DEPTH));
    end
  end

  assign pop_data_o = pop_take ? mem[rd_ptr] : '0;

  // Assertions
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH) else $error("occupancy above depth");
  p_full_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o == at_cap) else $error("full bit disagrees with occupancy");
  p_keep_full_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (at_cap && push_i) |=> at_cap) else $error("full queue lost occupancy on push");
  p_empty_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == '0 && pop_i && !push_i) |=> (cnt == '0)) else $error("empty pop changed count");
  p_nempty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |=> nempty_o) else $error("push did not set not-empty");
  p_thresh_r3: assert property (@(posedge clk) disable iff (!rst_n)
    thresh_o == (32'(cnt) > 32'($past(thr_i)))) else $error("threshold bit wrong");

endmodule

// File: rtl/rxlog_flag_route.sv
module rxlog_flag_route
  import rxlog_pkg::*;
#(
  parameter int unsigned NUM_CH = 8
) (
  input  logic [NUM_CH-1:0]   nempty_i,
  input  logic [NUM_CH-1:0]   thresh_i,
  input  logic [NUM_CH-1:0]   full_i,
  input  logic [2*NUM_CH-1:0] sel_i,
  output logic [NUM_CH-1:0]   flag_o,
  output logic                irq_o
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_route
    flag_src_e src;
    assign src = flag_src_e'(sel_i[2*g +: 2]);
    always_comb begin
      case (src)
        FSEL_NEMPTY: flag_o[g] = nempty_i[g];
        FSEL_THRESH: flag_o[g] = thresh_i[g];
        FSEL_FULL:   flag_o[g] = full_i[g];
        default:     flag_o[g] = 1'b0;
      endcase
    end
  end

  assign irq_o = |flag_o;

endmodule

// File: rtl/rxlog_fifo_bank.sv
module rxlog_fifo_bank #(
  parameter int unsigned NUM_CH = 8,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned THR_W  = 5,
  localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [CH_W-1:0]     wr_chan,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_strobe,
  input  logic [CH_W-1:0]     rd_chan,
  input  logic [THR_W-1:0]    thresh,
  input  logic [2*NUM_CH-1:0] flag_sel,
  output logic [DATA_W-1:0]   rd_data,
  output logic [NUM_CH-1:0]   stat_nempty,
  output logic [NUM_CH-1:0]   stat_thresh,
  output logic [NUM_CH-1:0]   stat_full,
  output logic [NUM_CH-1:0]   chan_flag,
  output logic                irq_pending
);
  logic [DATA_W-1:0] pop_data [NUM_CH];

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic push_here, pop_here;
    assign push_here = wr_valid  && (wr_chan == CH_W'(g));
    assign pop_here  = rd_strobe && (rd_chan == CH_W'(g));

    rxlog_chan_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W), .THR_W(THR_W)) u_fifo (
      .clk        (clk),
      .rst_n      (rst_n),
      .push_i     (push_here),
      .push_data_i(wr_data),
      .pop_i      (pop_here),
      .thr_i      (thresh),
      .pop_data_o (pop_data[g]),
      .nempty_o   (stat_nempty[g]),
      .thresh_o   (stat_thresh[g]),
      .full_o     (stat_full[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         rd_data <= '0;
    else if (rd_strobe) rd_data <= pop_data[rd_chan];
  end

  rxlog_flag_route #(.NUM_CH(NUM_CH)) u_route (
    .nempty_i(stat_nempty),
    .thresh_i(stat_thresh),
    .full_i  (stat_full),
    .sel_i   (flag_sel),
    .flag_o  (chan_flag),
    .irq_o   (irq_pending)
  );

  // Assertions
  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pending |-> (stat_nempty != '0)) else $error("interrupt with all queues empty");
  p_empty_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !stat_nempty[rd_chan]) |=> (rd_data == '0)) else $error("empty read not zero");
  p_rd_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_strobe |=> $stable(rd_data)) else $error("read data moved without strobe");

endmodule

// File: tb/tb_rxlog_fifo_bank.sv
`timescale 1ns/1ps
module tb_rxlog_fifo_bank;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [2:0]  wr_chan = '0;
  logic [31:0] wr_data = '0;
  logic        rd_strobe = 1'b0;
  logic [2:0]  rd_chan = '0;
  logic [4:0]  thresh = '0;
  logic [15:0] flag_sel = '0;
  logic [31:0] rd_data;
  logic [7:0]  stat_nempty, stat_thresh, stat_full, chan_flag;
  logic        irq_pending;

  always #2 clk = ~clk;

  rxlog_fifo_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_chan(wr_chan), .wr_data(wr_data),
    .rd_strobe(rd_strobe), .rd_chan(rd_chan), .thresh(thresh), .flag_sel(flag_sel),
    .rd_data(rd_data), .stat_nempty(stat_nempty), .stat_thresh(stat_thresh),
    .stat_full(stat_full), .chan_flag(chan_flag), .irq_pending(irq_pending)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;
  logic [31:0] mq [8][$];
  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        pend = 1'b0;

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // Driver: one cycle of stimulus, scoreboard updated from the requirements
  task automatic step(input logic pv, input int wc, input logic [31:0] wd,
                      input logic ps, input int rc, input string tag);
    wr_valid = pv; wr_chan = wc[2:0]; wr_data = wd;
    rd_strobe = ps; rd_chan = rc[2:0];
    if (ps) begin
      if (mq[rc].size() > 0) exp_q.push_back(mq[rc].pop_front());
      else                   exp_q.push_back(32'h0);
      tag_q.push_back(tag);
    end
    if (pv) begin
      mq[wc].push_back(wd);
      if (mq[wc].size() > 32) void'(mq[wc].pop_front());
    end
    @(negedge clk);
    wr_valid = 1'b0; rd_strobe = 1'b0;
  endtask

  // Monitor: compares popped words one cycle after the strobe
  always @(posedge clk) pend <= rd_strobe;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic check_status(string tag);
    logic [7:0] ne, th, fu, fl;
    for (int c = 0; c < 8; c++) begin
      ne[c] = mq[c].size() != 0;
      th[c] = mq[c].size() > int'(thresh);
      fu[c] = mq[c].size() == 32;
      case (flag_sel[2*c +: 2])
        2'b01:   fl[c] = ne[c];
        2'b10:   fl[c] = th[c];
        2'b11:   fl[c] = fu[c];
        default: fl[c] = 1'b0;
      endcase
    end
    chk({tag, " nempty"}, 32'(stat_nempty), 32'(ne));
    chk({tag, " thresh"}, 32'(stat_thresh), 32'(th));
    chk({tag, " full"},   32'(stat_full),   32'(fu));
    chk({tag, " flag"},   32'(chan_flag),   32'(fl));
    chk({tag, " irq (R11)"}, 32'(irq_pending), 32'(|fl));
  endtask

  task automatic finish_run();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check_status("R1");
    chk("R1 rd_data", rd_data, 32'h0);

    thresh = 5'd3;
    flag_sel[1:0] = 2'b10;
    @(negedge clk);
    // R2 and R3: fill channel 0 past the threshold, boundary at 3 words
    step(1, 0, 32'h0A00_0000, 0, 0, "R6");
    check_status("R2");
    for (int i = 1; i < 5; i++) begin
      step(1, 0, 32'h0A00_0000 + i, 0, 0, "R6");
      check_status("R3");
    end
    // R3: threshold changes, boundary equal value
    thresh = 5'd4; @(negedge clk); check_status("R3 thr4");
    thresh = 5'd5; @(negedge clk); check_status("R3 thr5");
    thresh = 5'd3; @(negedge clk);

    // R9: other channel traffic leaves channel 0 alone
    flag_sel[7:6] = 2'b01;
    step(1, 3, 32'h0300_0001, 0, 0, "R6");
    check_status("R9");

    // R4, R5: fill channel 5 past capacity
    for (int i = 0; i < 40; i++) begin
      step(1, 5, 32'h5000_0000 + i, 0, 0, "R6");
      if (i == 31) check_status("R4");
    end
    check_status("R5");

    // R10: each selector code on channel 5 (full, above threshold)
    for (int s = 0; s < 4; s++) begin
      flag_sel[11:10] = s[1:0];
      #1;
      check_status("R10");
      @(negedge clk);
    end

    // R8: simultaneous push and pop on full queue
    step(1, 5, 32'h5000_00FF, 1, 5, "R8");
    check_status("R8");

    // R6: drain channel 5 in order, including the overwrite survivors
    for (int i = 0; i < 32; i++) step(0, 0, 0, 1, 5, "R6 ch5");
    @(negedge clk);
    check_status("R6 drained");

    // R7: empty pops on channels 2 and 5
    step(0, 0, 0, 1, 2, "R7 ch2");
    step(0, 0, 0, 1, 5, "R7 ch5");
    @(negedge clk);
    check_status("R7");

    // Concurrent push on one channel and pop on another
    step(1, 1, 32'h0100_00A1, 1, 0, "R6 ch0");
    check_status("R9 concurrent");

    // R12: read data holds over idle cycles
    step(0, 0, 0, 1, 1, "R12 pop");
    repeat (3) @(negedge clk);
    chk("R12 hold", rd_data, 32'h0100_00A1);

    // R11: all selectors off then one channel enabled
    flag_sel = '0; #1; check_status("R11 off");
    flag_sel[1:0] = 2'b01; #1; check_status("R11 on");
    @(negedge clk);

    // Drain channel 0 and 3 to empty
    while (mq[0].size() > 0) step(0, 0, 0, 1, 0, "R6 ch0");
    step(0, 0, 0, 1, 3, "R6 ch3");
    @(negedge clk);
    check_status("R2 empty");
    finish_run();
  end
endmodule